// File: doc/BRIEF.md
# SPI Burst Shift Engine

This block is the serial engine of a byte-wide SPI master. A one-cycle start request launches a burst whose length in bytes is taken from a total-count input. A second count says how many of those bytes are pulled from the transmit FIFO. When that count runs out, the engine keeps clocking and shifts out 0x00 filler bytes until the total is reached. Every byte shifted in from MISO is pushed into the receive FIFO at the end of its eighth bit. Two cases are exceptions: discard mode is on, or the FIFO reports full. A full FIFO drops the byte and raises a sticky overflow flag. The FIFO storage, the register interface and the bit-rate divider all live outside. The divider supplies a one-cycle `tick` for every SCLK half-period.

The sequencer is a five-state machine. ST_IDLE leaves on start (IDLE->LEAD). ST_LEAD holds the chip select asserted for one tick. It then goes to ST_TRAIL if the total count is zero (LEAD->TRAIL), and otherwise to ST_FETCH (LEAD->FETCH). ST_FETCH loads either the next FIFO byte or a zero filler. It stalls while transmit data is owed but the FIFO is empty, then moves on (FETCH->SHIFT). ST_SHIFT produces sixteen SCLK edges. After the last one it returns for another byte (SHIFT->FETCH) or finishes (SHIFT->TRAIL). ST_TRAIL holds the chip select for one more tick, sets the completion flag and goes back to idle (TRAIL->IDLE).

Top module: `spi_burst_engine`

## Requirements
- R1: After reset the engine is idle (`busy`=0) and `sclk` equals `cpol`. Every chip-select line is at its inactive level, which is the inverse of `cs_pol_high`. `done_flag`, `ovf_flag` and `irq` are 0.
- R2: Each byte takes 16 SCLK edges, and SCLK rests at `cpol`. With `cpha`=0 the first bit is on MOSI before the first edge, both sides sample on leading edges and data changes on trailing edges. With `cpha`=1 data changes on leading edges and is sampled on trailing edges.
- R3: With `lsb_first`=1, bit 0 of each byte is sent and received first. With `lsb_first`=0, bit 7 goes first.
- R4: A burst exchanges exactly `burst_len` bytes. The first `tx_len` bytes are popped from the transmit FIFO, one `tx_pop` each. The remaining bytes are sent as 0x00 without popping.
- R5: Each received byte is pushed with one `rx_push` on `rx_data` at the end of its last bit, in arrival order, provided the discard mode is off and `rx_full` is 0.
- R6: With `rx_discard`=1, no byte is pushed and `ovf_flag` is not set.
- R7: A byte that completes while `rx_full`=1 and discard is off is dropped and sets `ovf_flag`. The flag stays set until `ovf_clr`.
- R8: At the end of a burst `busy` drops and `done_flag` is set. `done_clr` clears the flag, and a set in the same cycle wins.
- R9: `irq` is 1 exactly when (`done_flag` and `irq_en_done`) or (`ovf_flag` and `irq_en_ovf`).
- R10: A start request while `busy`=1 is ignored. The running burst keeps its length.
- R11: With `cs_manual`=0, only the line chosen by `cs_index` is driven active (level `cs_pol_high`). It goes active before the first SCLK edge of a burst and returns to inactive only once SCLK is back at its rest level. All other lines stay inactive.
- R12: With `cs_manual`=1, the chosen line is driven to `cs_level` whether or not a burst runs, and the other lines stay inactive.
- R13: A start with `burst_len`=0 sets `done_flag` with no SCLK edge and no FIFO traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One pulse per SCLK half-period from the divider |
| start | input | 1 | Burst start request |
| burst_len | input | 24 | Total bytes in the burst |
| tx_len | input | 24 | Bytes taken from the transmit FIFO |
| cpol | input | 1 | SCLK rest level |
| cpha | input | 1 | Clock phase select |
| lsb_first | input | 1 | Bit order, 1 = bit 0 first |
| cs_index | input | 2 | Chip-select line number |
| cs_manual | input | 1 | Manual chip-select mode |
| cs_level | input | 1 | Level on the chosen line in manual mode |
| cs_pol_high | input | 1 | 1 = chip select asserted high |
| rx_discard | input | 1 | Drop received bytes |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 8 | Transmit FIFO head byte |
| tx_pop | output | 1 | Pop the transmit FIFO head |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Push `rx_data` into the receive FIFO |
| rx_data | output | 8 | Received byte |
| done_clr | input | 1 | Clear the completion flag |
| ovf_clr | input | 1 | Clear the overflow flag |
| irq_en_done | input | 1 | Interrupt enable for completion |
| irq_en_ovf | input | 1 | Interrupt enable for overflow |
| busy | output | 1 | Burst in progress |
| done_flag | output | 1 | Burst complete status |
| ovf_flag | output | 1 | Receive overflow status |
| irq | output | 1 | Interrupt request |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_lines | output | 4 | Chip-select lines |

## Verification
A wrong sequencer state or count becomes visible at the chip-select and SCLK pins within the same burst. The bench records four things: the bytes a slave model receives, the number of SCLK edges, the FIFO pops and the pushed bytes. A bad edge counter or a wrong shift direction corrupts the first byte and shows after 16 edges. A bad burst or transmit counter shows as a wrong byte count or stray 0x00 bytes when `busy` drops. Flag errors show directly on `done_flag`, `ovf_flag` and `irq` one cycle after the event or clear.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_FETCH,
        ST_SHIFT,
        ST_TRAIL
    } seq_state_t;

    // bit presented next on the wire for the chosen order
    function automatic logic head_bit(input logic [BYTE_W-1:0] b, input logic lsb);
        return lsb ? b[0] : b[BYTE_W-1];
    endfunction

    // remove the bit just presented
    function automatic logic [BYTE_W-1:0] pop_bit(input logic [BYTE_W-1:0] b, input logic lsb);
        return lsb ? {1'b0, b[BYTE_W-1:1]} : {b[BYTE_W-2:0], 1'b0};
    endfunction

    // append a received bit in the chosen order
    function automatic logic [BYTE_W-1:0] push_bit(input logic [BYTE_W-1:0] b, input logic d,
                                                   input logic lsb);
        return lsb ? {d, b[BYTE_W-1:1]} : {b[BYTE_W-2:0], d};
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import spi_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              active,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int EDGES = 2 * BYTE_W;
    localparam int EW    = $clog2(EDGES);

    logic [EW-1:0]     edge_q;
    logic              phase_q;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_sh;
    logic              mosi_q;
    logic              step, last_edge, trailing, sample_now, emit_now;
    logic [BYTE_W-1:0] rx_next;

    always_comb begin
        step       = active & tick;
        trailing   = edge_q[0];
        last_edge  = (edge_q == EW'(EDGES - 1));
        sample_now = step & (cpha ? trailing : ~trailing);
        emit_now   = step & (cpha ? ~trailing : (trailing & ~last_edge));
        rx_next    = sample_now ? push_bit(rx_sh, miso, lsb_first) : rx_sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q  <= '0;
            phase_q <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            mosi_q  <= 1'b0;
        end else if (load) begin
            edge_q  <= '0;
            phase_q <= 1'b0;
            if (cpha) begin
                tx_sh <= load_data;
            end else begin
                tx_sh  <= pop_bit(load_data, lsb_first);
                mosi_q <= head_bit(load_data, lsb_first);
            end
        end else if (step) begin
            phase_q <= ~phase_q;
            edge_q  <= last_edge ? '0 : edge_q + 1'b1;
            if (emit_now) begin
                mosi_q <= head_bit(tx_sh, lsb_first);
                tx_sh  <= pop_bit(tx_sh, lsb_first);
            end
            if (sample_now) rx_sh <= rx_next;
        end
    end

    assign sclk      = cpol ^ phase_q;
    assign mosi      = mosi_q;
    assign byte_done = step & last_edge;
    assign rx_byte   = rx_next;

    // SCLK must be back at rest whenever the shifter is not running a byte
    assert_rest_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active) |-> (sclk == cpol));

endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
    import spi_burst_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic [CNT_W-1:0]  tx_len,
    input  logic              tx_empty,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              byte_done,
    output logic              busy,
    output logic              shifting,
    output logic              tx_pop,
    output logic              load,
    output logic [BYTE_W-1:0] load_data,
    output logic              burst_end
);
    seq_state_t       st, st_nx;
    logic [CNT_W-1:0] burst_rem, tx_rem;
    logic             owe_tx, fetch_go, final_byte;

    assign owe_tx     = (tx_rem != '0);
    assign fetch_go   = (st == ST_FETCH) && (!owe_tx || !tx_empty);
    assign final_byte = (burst_rem == CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start)     st_nx = ST_LEAD;
            ST_LEAD:  if (tick)      st_nx = (burst_rem == '0) ? ST_TRAIL : ST_FETCH;
            ST_FETCH: if (fetch_go)  st_nx = ST_SHIFT;
            ST_SHIFT: if (byte_done) st_nx = final_byte ? ST_TRAIL : ST_FETCH;
            ST_TRAIL: if (tick)      st_nx = ST_IDLE;
            default:                 st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (st != ST_IDLE);
        shifting  = (st == ST_SHIFT);
        load      = fetch_go;
        tx_pop    = fetch_go && owe_tx;
        load_data = owe_tx ? tx_data : '0;
        burst_end = (st == ST_TRAIL) && tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_rem <= '0;
            tx_rem    <= '0;
        end else begin
            if (st == ST_IDLE && start) begin
                burst_rem <= burst_len;
                tx_rem    <= tx_len;
            end
            if (tx_pop) tx_rem <= tx_rem - 1'b1;
            if (st == ST_SHIFT && byte_done) burst_rem <= burst_rem - 1'b1;
        end
    end

    assert_edges_in_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> (st == ST_SHIFT));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT && start && !byte_done) |=>
            (st == ST_SHIFT && burst_rem == $past(burst_rem)));

    assert_pop_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

endmodule

// File: rtl/spi_cs_select.sv
module spi_cs_select #(
    parameter int NUM_CS = 4
) (
    input  logic                      active,
    input  logic [$clog2(NUM_CS)-1:0] sel,
    input  logic                      manual,
    input  logic                      level,
    input  logic                      pol_high,
    output logic [NUM_CS-1:0]         lines
);
    localparam int IW = $clog2(NUM_CS);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        always_comb begin
            if (sel == IW'(i))
                lines[i] = manual ? level : (active ? pol_high : ~pol_high);
            else
                lines[i] = ~pol_high;
        end
    end

endmodule

// File: rtl/spi_burst_status.sv
module spi_burst_status (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_end,
    input  logic byte_done,
    input  logic rx_discard,
    input  logic rx_full,
    input  logic done_clr,
    input  logic ovf_clr,
    input  logic irq_en_done,
    input  logic irq_en_ovf,
    output logic rx_push,
    output logic done_flag,
    output logic ovf_flag,
    output logic irq
);
    logic ovf_set;

    assign rx_push = byte_done & ~rx_discard & ~rx_full;
    assign ovf_set = byte_done & ~rx_discard &  rx_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            if (burst_end)     done_flag <= 1'b1;
            else if (done_clr) done_flag <= 1'b0;
            if (ovf_set)       ovf_flag  <= 1'b1;
            else if (ovf_clr)  ovf_flag  <= 1'b0;
        end
    end

    assign irq = (done_flag & irq_en_done) | (ovf_flag & irq_en_ovf);

    assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !burst_end) |=> !done_flag);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    assert_discard_no_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_discard && !ovf_flag) |=> !ovf_flag);

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int NUM_CS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      start,
    input  logic [CNT_W-1:0]          burst_len,
    input  logic [CNT_W-1:0]          tx_len,
    input  logic                      cpol,
    input  logic                      cpha,
    input  logic                      lsb_first,
    input  logic [$clog2(NUM_CS)-1:0] cs_index,
    input  logic                      cs_manual,
    input  logic                      cs_level,
    input  logic                      cs_pol_high,
    input  logic                      rx_discard,
    input  logic                      tx_empty,
    input  logic [7:0]                tx_data,
    output logic                      tx_pop,
    input  logic                      rx_full,
    output logic                      rx_push,
    output logic [7:0]                rx_data,
    input  logic                      done_clr,
    input  logic                      ovf_clr,
    input  logic                      irq_en_done,
    input  logic                      irq_en_ovf,
    output logic                      busy,
    output logic                      done_flag,
    output logic                      ovf_flag,
    output logic                      irq,
    input  logic                      miso,
    output logic                      sclk,
    output logic                      mosi,
    output logic [NUM_CS-1:0]         cs_lines
);
    logic              shifting, load, byte_done, burst_end;
    logic [BYTE_W-1:0] load_data;

    spi_burst_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .burst_len(burst_len), .tx_len(tx_len),
        .tx_empty(tx_empty), .tx_data(tx_data), .byte_done(byte_done),
        .busy(busy), .shifting(shifting), .tx_pop(tx_pop),
        .load(load), .load_data(load_data), .burst_end(burst_end)
    );

    spi_byte_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick), .active(shifting),
        .load(load), .load_data(load_data),
        .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .miso(miso),
        .sclk(sclk), .mosi(mosi), .byte_done(byte_done), .rx_byte(rx_data)
    );

    spi_cs_select #(.NUM_CS(NUM_CS)) u_cs (
        .active(busy), .sel(cs_index), .manual(cs_manual),
        .level(cs_level), .pol_high(cs_pol_high), .lines(cs_lines)
    );

    spi_burst_status u_stat (
        .clk(clk), .rst_n(rst_n), .burst_end(burst_end), .byte_done(byte_done),
        .rx_discard(rx_discard), .rx_full(rx_full),
        .done_clr(done_clr), .ovf_clr(ovf_clr),
        .irq_en_done(irq_en_done), .irq_en_ovf(irq_en_ovf),
        .rx_push(rx_push), .done_flag(done_flag), .ovf_flag(ovf_flag), .irq(irq)
    );

    assert_single_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_lines ^ {NUM_CS{~cs_pol_high}}));

    assert_cs_covers_edges_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cs_manual && !$stable(sclk)) |-> (cs_lines[cs_index] == cs_pol_high));

    assert_idle_rest_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> (sclk == cpol && !rx_push && !tx_pop));

endmodule

// File: tb/tb_spi_burst_engine.sv
module tb_spi_burst_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic [23:0] burst_len = '0;
    logic [23:0] tx_len = '0;
    logic        cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
    logic [1:0]  cs_index = '0;
    logic        cs_manual = 1'b0, cs_level = 1'b0, cs_pol_high = 1'b0;
    logic        rx_discard = 1'b0;
    logic        tx_empty;
    logic [7:0]  tx_data;
    logic        tx_pop;
    logic        rx_full;
    logic        rx_push;
    logic [7:0]  rx_data;
    logic        done_clr = 1'b0, ovf_clr = 1'b0;
    logic        irq_en_done = 1'b0, irq_en_ovf = 1'b0;
    logic        busy, done_flag, ovf_flag, irq;
    logic        miso = 1'b0;
    logic        sclk, mosi;
    logic [3:0]  cs_lines;

    int vectors = 0;
    int fails = 0;
    int tick_div = 1;

    logic [7:0] txq [0:127];
    logic [7:0] rxq [0:127];
    int tx_rd = 0, tx_wr = 0, rx_wr = 0, rx_cap = 128;

    // slave model state
    logic [7:0] s_got [0:127];
    logic [7:0] s_sh;
    int s_bits = 0, s_idx = 0, s_edges = 0, s_bad_cs = 0;

    assign tx_empty = (tx_rd == tx_wr);
    assign tx_data  = txq[tx_rd[6:0]];
    assign rx_full  = (rx_wr >= rx_cap);

    spi_burst_engine dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .burst_len(burst_len), .tx_len(tx_len),
        .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first),
        .cs_index(cs_index), .cs_manual(cs_manual), .cs_level(cs_level),
        .cs_pol_high(cs_pol_high), .rx_discard(rx_discard),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
        .done_clr(done_clr), .ovf_clr(ovf_clr),
        .irq_en_done(irq_en_done), .irq_en_ovf(irq_en_ovf),
        .busy(busy), .done_flag(done_flag), .ovf_flag(ovf_flag), .irq(irq),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs_lines(cs_lines)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] m_pat(input int i);
        return 8'hC1 + 8'(i * 37);
    endfunction

    function automatic logic [7:0] s_pat(input int i);
        return 8'h3C ^ 8'(i * 23);
    endfunction

    function automatic logic wire_bit(input logic [7:0] b, input int n, input logic lsb);
        return lsb ? b[n] : b[7-n];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // tick source
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt++;
            tick = ((cnt % tick_div) == 0);
        end
    end

    // FIFO models
    initial begin
        forever begin
            @(posedge clk);
            if (tx_pop) tx_rd <= tx_rd + 1;
            if (rx_push) begin
                rxq[rx_wr[6:0]] <= rx_data;
                rx_wr <= rx_wr + 1;
            end
        end
    end

    // slave device model
    initial begin
        forever begin
            @(sclk);
            if (busy) begin
                s_edges++;
                if (cs_lines[cs_index] != cs_pol_high) s_bad_cs++;
                if (sclk != cpol) begin
                    if (!cpha) begin
                        s_sh[lsb_first ? s_bits : 7 - s_bits] = mosi;
                        s_bits++;
                    end else begin
                        miso = wire_bit(s_pat(s_idx), s_bits, lsb_first);
                    end
                end else begin
                    if (cpha) begin
                        s_sh[lsb_first ? s_bits : 7 - s_bits] = mosi;
                        s_bits++;
                    end
                    if (s_bits == 8) begin
                        s_got[s_idx[6:0]] = s_sh;
                        s_idx++;
                        s_bits = 0;
                        s_sh = '0;
                        if (!cpha) miso = wire_bit(s_pat(s_idx), 0, lsb_first);
                    end else if (!cpha) begin
                        miso = wire_bit(s_pat(s_idx), s_bits, lsb_first);
                    end
                end
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        repeat (2) @(negedge clk);
        while (busy && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic clear_flags();
        @(negedge clk); done_clr = 1'b1; ovf_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0; ovf_clr = 1'b0;
    endtask

    // one full burst with all port-level checks
    task automatic run_burst(input logic pol, input logic pha, input logic lsb,
                             input logic [1:0] idx, input int nb, input int nt,
                             input logic disc, input int cap, input int div,
                             input bit restart, input string tag);
        int exp_rx;
        @(negedge clk);
        cpol = pol; cpha = pha; lsb_first = lsb; cs_index = idx; cs_manual = 1'b0;
        rx_discard = disc; tick_div = div;
        tx_rd = 0; tx_wr = nt; rx_wr = 0; rx_cap = cap;
        for (int i = 0; i < nt; i++) txq[i] = m_pat(i);
        s_bits = 0; s_idx = 0; s_edges = 0; s_bad_cs = 0; s_sh = '0;
        miso = wire_bit(s_pat(0), 0, lsb);
        burst_len = 24'(nb); tx_len = 24'(nt);
        @(negedge clk);
        pulse_start();
        if (restart) begin
            repeat (12) @(negedge clk);
            burst_len = 24'(nb + 3);
            pulse_start();
        end
        wait_idle();
        check(s_idx == nb, {tag, " R4 R10 byte count"}, s_idx, nb);
        for (int i = 0; i < nb && i < 128; i++) begin
            logic [7:0] e = (i < nt) ? m_pat(i) : 8'h00;
            check(s_got[i] == e, {tag, " R2 R3 R4 mosi byte"}, s_got[i], e);
        end
        check(tx_rd == nt, {tag, " R4 pops"}, tx_rd, nt);
        exp_rx = disc ? 0 : ((nb < cap) ? nb : cap);
        check(rx_wr == exp_rx, {tag, " R5 R6 R7 push count"}, rx_wr, exp_rx);
        for (int i = 0; i < exp_rx; i++)
            check(rxq[i] == s_pat(i), {tag, " R3 R5 rx byte"}, rxq[i], s_pat(i));
        check(s_edges == 16 * nb, {tag, " R2 edges"}, s_edges, 16 * nb);
        check(s_bad_cs == 0, {tag, " R11 edge without cs"}, s_bad_cs, 0);
        check(cs_lines == {4{~cs_pol_high}}, {tag, " R11 cs released"}, cs_lines, {4{~cs_pol_high}});
        check(sclk == pol, {tag, " R2 sclk rest"}, sclk, pol);
        check(done_flag == 1'b1, {tag, " R8 done"}, done_flag, 1);
        check(ovf_flag == (!disc && nb > cap), {tag, " R6 R7 ovf"}, ovf_flag, (!disc && nb > cap));
    endtask

    task automatic t_reset();
        check(busy == 1'b0 && sclk == cpol, "R1 idle", {busy, sclk}, {1'b0, cpol});
        check(cs_lines == 4'hF, "R1 cs inactive", cs_lines, 4'hF);
        check({done_flag, ovf_flag, irq} == 3'b000, "R1 flags", {done_flag, ovf_flag, irq}, 0);
    endtask

    task automatic t_irq();
        run_burst(1'b0, 1'b0, 1'b0, 2'd0, 1, 1, 1'b0, 128, 1, 1'b0, "irq");
        @(negedge clk); irq_en_done = 1'b0;
        @(negedge clk); check(irq == 1'b0, "R9 masked done", irq, 0);
        irq_en_done = 1'b1;
        @(negedge clk); check(irq == 1'b1, "R9 enabled done", irq, 1);
        done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        check(done_flag == 1'b0 && irq == 1'b0, "R8 R9 clear", {done_flag, irq}, 0);
        irq_en_done = 1'b0;
    endtask

    task automatic t_overflow();
        run_burst(1'b1, 1'b0, 1'b0, 2'd3, 3, 3, 1'b0, 1, 2, 1'b0, "ovf");
        irq_en_ovf = 1'b1;
        @(negedge clk); check(irq == 1'b1, "R7 R9 ovf irq", irq, 1);
        repeat (3) @(negedge clk);
        check(ovf_flag == 1'b1, "R7 sticky", ovf_flag, 1);
        clear_flags();
        check(ovf_flag == 1'b0 && irq == 1'b0, "R7 cleared", {ovf_flag, irq}, 0);
        irq_en_ovf = 1'b0;
    endtask

    task automatic t_zero();
        run_burst(1'b0, 1'b1, 1'b0, 2'd1, 0, 0, 1'b0, 128, 1, 1'b0, "zero R13");
        clear_flags();
    endtask

    task automatic t_manual();
        @(negedge clk);
        cs_manual = 1'b1; cs_index = 2'd1; cs_level = 1'b0; cs_pol_high = 1'b0;
        @(negedge clk); check(cs_lines == 4'b1101, "R12 manual low", cs_lines, 4'b1101);
        cs_level = 1'b1;
        @(negedge clk); check(cs_lines == 4'b1111, "R12 manual high", cs_lines, 4'b1111);
        cs_manual = 1'b0; cs_pol_high = 1'b1;
        @(negedge clk); check(cs_lines == 4'b0000, "R11 idle active-high", cs_lines, 4'b0000);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run_burst(1'b0, 1'b0, 1'b0, 2'd0, 2, 2, 1'b0, 128, 1, 1'b0, "mode0 msb");
        clear_flags();
        run_burst(1'b1, 1'b1, 1'b1, 2'd2, 3, 3, 1'b0, 128, 3, 1'b0, "mode3 lsb");
        clear_flags();
        run_burst(1'b0, 1'b1, 1'b0, 2'd1, 2, 2, 1'b0, 128, 2, 1'b0, "mode1");
        clear_flags();
        run_burst(1'b1, 1'b0, 1'b1, 2'd3, 2, 2, 1'b0, 128, 1, 1'b0, "mode2 lsb");
        clear_flags();
        run_burst(1'b0, 1'b0, 1'b0, 2'd0, 4, 1, 1'b0, 128, 1, 1'b0, "filler R4");
        clear_flags();
        run_burst(1'b0, 1'b1, 1'b1, 2'd2, 3, 3, 1'b1, 128, 1, 1'b0, "discard R6");
        clear_flags();
        run_burst(1'b0, 1'b0, 1'b0, 2'd1, 2, 2, 1'b0, 128, 2, 1'b1, "restart R10");
        clear_flags();
        t_irq();
        t_overflow();
        t_zero();
        t_manual();
        cs_pol_high = 1'b1;
        run_burst(1'b0, 1'b0, 1'b0, 2'd2, 2, 2, 1'b0, 128, 1, 1'b0, "active-high R11");
        clear_flags();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule